// File: doc/BRIEF.md
# Amplitude Envelope Signature Checker

This block screens an analogue-to-digital converter by the shape of its folded output. A single period of converter codes arrives as a stream, one code per sample index, already rearranged so that the period starts at its lowest level. In learn mode the block records, for every index, the smallest and the largest code seen across the captures of several known-good devices. That pair forms an acceptance band.

In test mode each code from the device under test is compared with the band at its index. The distance by which the code lies outside the band is added to a per-section deviation sum, the numerator. The band width is added to a per-section band sum, the denominator. The period is divided into four index sections whose bounds are inputs. Learn captures and test captures must use the same bounds. When the last index of the fourth section has been scored, the block raises a one-cycle completion pulse. A verdict for each section is then valid. The verdict compares the ratio of the two sums with a percentage threshold, using multiplications only.

Top module: `band_signature_checker`

## Requirements
- R1: The first learn capture after `clear_i` loads both the band minimum and the band maximum of each index it visits with the incoming code. A later test then sees a band of zero width at those indices.
- R2: Each later learn capture lowers the minimum when its code is smaller and raises the maximum when its code is larger. Each index therefore holds the smallest and largest code over all captures since the clear.
- R3: A test code above the band maximum contributes code minus maximum to the numerator of its section.
- R4: A test code below the band minimum contributes minimum minus code to the numerator of its section.
- R5: A test code inside the closed band, the bounds included, contributes zero to the numerator.
- R6: A test sample counts only in the lowest-numbered section s whose inclusive range `[lo_s, hi_s]` contains its index. Section s is field s of `sec_lo_i`/`sec_hi_i`, in bits `[s*8 +: 8]` at default size. Samples outside every section, and all learn samples, leave the numerators and denominators unchanged.
- R7: After completion, `num_o` field s (bits `[s*21 +: 21]` at default size) holds the sum of deviations over the section's test samples. `den_o` field s holds the sum of (maximum minus minimum) over the same samples.
- R8: `done_o` is high for exactly the one cycle after an accepted test sample (mode 1) whose index equals the upper bound of section 3.
- R9: Bit s of `sec_fail_o` is 1 when numerator×100 is greater than `thr_pct_i`×denominator. Equality passes. `fail_o` is the OR of the four bits.
- R10: When a section's denominator is zero, the section fails if its numerator is nonzero and passes if the numerator is zero.
- R11: The first accepted in-section test sample after a completion pulse restarts all eight sums from zero.
- R12: `clear_i` zeroes all sums and re-arms first-capture loading in the next cycle. A sample presented with it is ignored and cannot produce a completion pulse.
- R13: After reset all sums are zero and `done_o`, `sec_fail_o` and `fail_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Zero sums, restart learning with direct load |
| mode_i | input | 1 | 0 = learn, 1 = test |
| smp_vld_i | input | 1 | Sample strobe |
| smp_idx_i | input | 8 | Index within the folded period |
| smp_code_i | input | 12 | Converter code |
| sec_lo_i | input | 32 | Four section lower bounds, 8 bits each |
| sec_hi_i | input | 32 | Four section upper bounds, 8 bits each |
| thr_pct_i | input | 7 | Allowed deviation in percent of band sum |
| num_o | output | 84 | Four deviation sums, 21 bits each |
| den_o | output | 84 | Four band sums, 21 bits each |
| sec_fail_o | output | 4 | Per-section verdict |
| fail_o | output | 1 | Any section failed |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the following about the inputs:
- Section bounds and the threshold stay constant while a capture is streaming.
- Each section satisfies lo ≤ hi.
- Every learn capture ends at the upper bound of section 3, which is what ends direct loading.

The stimulus reprograms bounds and threshold only between captures. Every capture visits its indices in ascending order and ends with the last index of section 3. Indices outside all sections are inserted before that final sample. The single-index section layout places codes exactly on the band edges and exactly on the threshold ratio. An overlapping layout exercises the section priority.

// File: rtl/bsc_pkg.sv
// Shared constants and the mode encoding for the band signature checker.
package bsc_pkg;
    localparam int NSEC      = 4;     // sections per folded period
    localparam int PCT_SCALE = 100;   // percent scale in the verdict

    typedef enum logic {
        MODE_LEARN = 1'b0,
        MODE_TEST  = 1'b1
    } bsc_mode_e;
endpackage

// File: rtl/bsc_sec_map.sv
// Section decoder. Maps a sample index onto the lowest-numbered section
// whose inclusive [lo, hi] range contains it. Also flags the index that
// closes the period, which is the upper bound of the last section.
// Assumes lo <= hi for each section; overlaps resolve by priority.
module bsc_sec_map #(
    parameter int IDX_W = 8,
    parameter int NSEC  = 4,
    localparam int SEL_W = $clog2(NSEC)
) (
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [NSEC*IDX_W-1:0] lo_i,
    input  logic [NSEC*IDX_W-1:0] hi_i,
    output logic                  hit_o,
    output logic [SEL_W-1:0]      sel_o,
    output logic                  last_o
);
    logic [NSEC-1:0] in_rng;

    for (genvar s = 0; s < NSEC; s++) begin : g_rng
        // Range test of one section.
        assign in_rng[s] = (idx_i >= lo_i[s*IDX_W +: IDX_W]) &&
                           (idx_i <= hi_i[s*IDX_W +: IDX_W]);
    end

    // Priority pick: the lowest section number wins.
    always_comb begin
        sel_o = '0;
        for (int s = NSEC - 1; s >= 0; s--) begin
            if (in_rng[s]) sel_o = SEL_W'(s);
        end
    end

    assign hit_o  = |in_rng;
    assign last_o = (idx_i == hi_i[(NSEC-1)*IDX_W +: IDX_W]);
endmodule

// File: rtl/bsc_envelope.sv
// Acceptance band store. Holds the minimum and maximum code per index in
// register arrays. The first learn capture after clear loads both bounds
// directly. Later captures widen them. A capture ends with the sample
// flagged by last_i. Read is combinational at the same index.
module bsc_envelope #(
    parameter int CODE_W = 12,
    parameter int DEPTH  = 256,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              we_i,
    input  logic              last_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] lo_o,
    output logic [CODE_W-1:0] hi_o
);
    logic [CODE_W-1:0] lo_q [DEPTH];
    logic [CODE_W-1:0] hi_q [DEPTH];
    logic              first_q;

    // First-capture flag: armed by reset and clear, dropped at capture end.
    always_ff @(posedge clk) begin
        if (!rst_n)                 first_q <= 1'b1;
        else if (clear_i)           first_q <= 1'b1;
        else if (we_i && last_i)    first_q <= 1'b0;
    end

    // Band bounds: direct load on the first capture, compare-and-replace later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                lo_q[k] <= '0;
                hi_q[k] <= '0;
            end
        end else if (we_i && !clear_i) begin
            if (first_q) begin
                lo_q[idx_i] <= code_i;
                hi_q[idx_i] <= code_i;
            end else begin
                if (code_i < lo_q[idx_i]) lo_q[idx_i] <= code_i;
                if (code_i > hi_q[idx_i]) hi_q[idx_i] <= code_i;
            end
        end
    end

    assign lo_o = lo_q[idx_i];
    assign hi_o = hi_q[idx_i];
endmodule

// File: rtl/bsc_accum.sv
// Deviation scoring and per-section sums. For each accepted test sample it
// computes the excursion outside [lo, hi] and adds it to the numerator of
// the chosen section. It adds hi - lo to the denominator of that section.
// After a period closes, the next scored sample restarts all sums.
// Assumes hi >= lo at every index, which the band store guarantees.
module bsc_accum #(
    parameter int CODE_W = 12,
    parameter int ACC_W  = 21,
    parameter int NSEC   = 4,
    localparam int SEL_W = $clog2(NSEC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  acc_en_i,
    input  logic                  last_en_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  logic [CODE_W-1:0]     code_i,
    input  logic [CODE_W-1:0]     env_lo_i,
    input  logic [CODE_W-1:0]     env_hi_i,
    output logic [NSEC*ACC_W-1:0] num_o,
    output logic [NSEC*ACC_W-1:0] den_o,
    output logic                  done_o
);
    logic [CODE_W-1:0] dev;
    logic [CODE_W-1:0] band;
    logic [ACC_W-1:0]  dev_ext;
    logic [ACC_W-1:0]  band_ext;
    logic              restart_q;
    logic              done_q;

    // Excursion outside the closed band, zero inside it.
    always_comb begin
        if (code_i > env_hi_i)      dev = code_i - env_hi_i;
        else if (code_i < env_lo_i) dev = env_lo_i - code_i;
        else                        dev = '0;
        band = env_hi_i - env_lo_i;
    end

    assign dev_ext  = {{(ACC_W-CODE_W){1'b0}}, dev};
    assign band_ext = {{(ACC_W-CODE_W){1'b0}}, band};

    // Restart flag: set after a completed period, consumed by the next score.
    always_ff @(posedge clk) begin
        if (!rst_n)         restart_q <= 1'b1;
        else if (clear_i)   restart_q <= 1'b1;
        else if (last_en_i) restart_q <= 1'b1;
        else if (acc_en_i)  restart_q <= 1'b0;
    end

    // Completion pulse, one cycle after the closing sample.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= last_en_i && !clear_i;
    end

    for (genvar s = 0; s < NSEC; s++) begin : g_sum
        logic [ACC_W-1:0] num_q;
        logic [ACC_W-1:0] den_q;
        logic             mine;

        assign mine = (sel_i == SEL_W'(s));

        // Numerator and denominator of one section.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                num_q <= '0;
                den_q <= '0;
            end else if (acc_en_i) begin
                if (restart_q) begin
                    num_q <= mine ? dev_ext  : '0;
                    den_q <= mine ? band_ext : '0;
                end else if (mine) begin
                    num_q <= num_q + dev_ext;
                    den_q <= den_q + band_ext;
                end
            end
        end

        assign num_o[s*ACC_W +: ACC_W] = num_q;
        assign den_o[s*ACC_W +: ACC_W] = den_q;
    end

    assign done_o = done_q;
endmodule

// File: rtl/bsc_judge.sv
// Section verdicts without a divider. A section fails when
// num * 100 > thr * den, or when den is zero while num is nonzero.
// Purely combinational, so it follows the sums directly.
module bsc_judge #(
    parameter int ACC_W = 21,
    parameter int PCT_W = 7,
    parameter int NSEC  = 4,
    localparam int PROD_W = ACC_W + PCT_W + 7
) (
    input  logic [NSEC*ACC_W-1:0] num_i,
    input  logic [NSEC*ACC_W-1:0] den_i,
    input  logic [PCT_W-1:0]      thr_i,
    output logic [NSEC-1:0]       fail_o
);
    import bsc_pkg::*;

    for (genvar s = 0; s < NSEC; s++) begin : g_cmp
        logic [ACC_W-1:0]  num_s;
        logic [ACC_W-1:0]  den_s;
        logic [PROD_W-1:0] lhs;
        logic [PROD_W-1:0] rhs;

        assign num_s = num_i[s*ACC_W +: ACC_W];
        assign den_s = den_i[s*ACC_W +: ACC_W];

        // Cross-multiplied ratio test of one section.
        always_comb begin
            lhs = PROD_W'(num_s) * PROD_W'(PCT_SCALE);
            rhs = PROD_W'(den_s) * PROD_W'(thr_i);
            fail_o[s] = (lhs > rhs) || ((den_s == '0) && (num_s != '0));
        end
    end
endmodule

// File: rtl/band_signature_checker.sv
// Top level of the amplitude envelope signature checker. Learn samples build
// a per-index min/max band. Test samples are scored against it in four
// programmable index sections. Assumes folded, lowest-level-first input,
// bounds and threshold stable during a capture, and every capture closing
// at the upper bound of the last section.
module band_signature_checker #(
    parameter int CODE_W    = 12,
    parameter int DEPTH     = 256,
    parameter int SEC_N_MAX = 256,
    parameter int PCT_W     = 7,
    localparam int NSEC     = bsc_pkg::NSEC,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int ACC_W    = CODE_W + $clog2(SEC_N_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  mode_i,
    input  logic                  smp_vld_i,
    input  logic [IDX_W-1:0]      smp_idx_i,
    input  logic [CODE_W-1:0]     smp_code_i,
    input  logic [NSEC*IDX_W-1:0] sec_lo_i,
    input  logic [NSEC*IDX_W-1:0] sec_hi_i,
    input  logic [PCT_W-1:0]      thr_pct_i,
    output logic [NSEC*ACC_W-1:0] num_o,
    output logic [NSEC*ACC_W-1:0] den_o,
    output logic [NSEC-1:0]       sec_fail_o,
    output logic                  fail_o,
    output logic                  done_o
);
    import bsc_pkg::*;

    localparam int SEL_W = $clog2(NSEC);

    logic              take;
    logic              learn_we;
    logic              is_test;
    logic              hit;
    logic              last;
    logic [SEL_W-1:0]  sel;
    logic [CODE_W-1:0] env_lo;
    logic [CODE_W-1:0] env_hi;

    assign take     = smp_vld_i && !clear_i;
    assign is_test  = (bsc_mode_e'(mode_i) == MODE_TEST);
    assign learn_we = take && !is_test;

    bsc_sec_map #(.IDX_W(IDX_W), .NSEC(NSEC)) map_i (
        .idx_i  (smp_idx_i),
        .lo_i   (sec_lo_i),
        .hi_i   (sec_hi_i),
        .hit_o  (hit),
        .sel_o  (sel),
        .last_o (last)
    );

    bsc_envelope #(.CODE_W(CODE_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) env_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .we_i    (learn_we),
        .last_i  (last),
        .idx_i   (smp_idx_i),
        .code_i  (smp_code_i),
        .lo_o    (env_lo),
        .hi_o    (env_hi)
    );

    bsc_accum #(.CODE_W(CODE_W), .ACC_W(ACC_W), .NSEC(NSEC)) acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .acc_en_i  (take && is_test && hit),
        .last_en_i (take && is_test && last),
        .sel_i     (sel),
        .code_i    (smp_code_i),
        .env_lo_i  (env_lo),
        .env_hi_i  (env_hi),
        .num_o     (num_o),
        .den_o     (den_o),
        .done_o    (done_o)
    );

    bsc_judge #(.ACC_W(ACC_W), .PCT_W(PCT_W), .NSEC(NSEC)) jdg_i (
        .num_i  (num_o),
        .den_i  (den_o),
        .thr_i  (thr_pct_i),
        .fail_o (sec_fail_o)
    );

    assign fail_o = |sec_fail_o;
endmodule

// File: rtl/bsc_chk.sv
// Property checker for the band signature checker, bound to the top.
module bsc_chk #(
    parameter int IDX_W = 8,
    parameter int ACC_W = 21,
    parameter int NSEC  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clear_i,
    input logic                  mode_i,
    input logic                  smp_vld_i,
    input logic [IDX_W-1:0]      smp_idx_i,
    input logic [NSEC*IDX_W-1:0] sec_hi_i,
    input logic [NSEC*ACC_W-1:0] num_o,
    input logic [NSEC*ACC_W-1:0] den_o,
    input logic [NSEC-1:0]       sec_fail_o,
    input logic                  done_o
);
    // R12
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (num_o == '0) && (den_o == '0) && !done_o);

    // R8
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(smp_vld_i && !clear_i && mode_i &&
                         (smp_idx_i == sec_hi_i[(NSEC-1)*IDX_W +: IDX_W])));

    // R6
    learn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && !mode_i && !clear_i) |=> $stable(num_o) && $stable(den_o));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld_i && !clear_i) |=> $stable(num_o) && $stable(den_o));

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        // R10
        zero_den_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((den_o[s*ACC_W +: ACC_W] == '0) && (num_o[s*ACC_W +: ACC_W] != '0))
                |-> sec_fail_o[s]);

        // R10
        zero_num_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (num_o[s*ACC_W +: ACC_W] == '0) |-> !sec_fail_o[s]);
    end
endmodule

bind band_signature_checker bsc_chk #(
    .IDX_W (IDX_W),
    .ACC_W (ACC_W),
    .NSEC  (NSEC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .mode_i     (mode_i),
    .smp_vld_i  (smp_vld_i),
    .smp_idx_i  (smp_idx_i),
    .sec_hi_i   (sec_hi_i),
    .num_o      (num_o),
    .den_o      (den_o),
    .sec_fail_o (sec_fail_o),
    .done_o     (done_o)
);

// File: tb/band_signature_checker_tb_top.sv
// Scoreboard bench: the driver keeps a requirement-level model and queues the
// expected sums and verdicts. The monitor pops them at each completion pulse.
module band_signature_checker_tb_top;
    localparam int IDX_W = 8;
    localparam int ACC_W = 21;
    localparam int NS    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             mode = 1'b0;
    logic             vld = 1'b0;
    logic [IDX_W-1:0] sidx = '0;
    logic [11:0]      scode = '0;
    logic [31:0]      lo_v = '0;
    logic [31:0]      hi_v = '0;
    logic [6:0]       thr = '0;
    logic [NS*ACC_W-1:0] num_w;
    logic [NS*ACC_W-1:0] den_w;
    logic [NS-1:0]    sfail;
    logic             fail_w;
    logic             done_w;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // Requirement-level model state.
    int  m_min [256];
    int  m_max [256];
    bit  m_first = 1'b1;
    int  e_num [NS];
    int  e_den [NS];
    bit  e_restart = 1'b1;
    int  q_num [$];
    int  q_den [$];
    int  q_fail [$];

    always #4 clk = ~clk;   // 125 MHz

    band_signature_checker dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clr),
        .mode_i     (mode),
        .smp_vld_i  (vld),
        .smp_idx_i  (sidx),
        .smp_code_i (scode),
        .sec_lo_i   (lo_v),
        .sec_hi_i   (hi_v),
        .thr_pct_i  (thr),
        .num_o      (num_w),
        .den_o      (den_w),
        .sec_fail_o (sfail),
        .fail_o     (fail_w),
        .done_o     (done_w)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int gnum(input int s);
        return int'(num_w[s*ACC_W +: ACC_W]);
    endfunction

    function automatic int gden(input int s);
        return int'(den_w[s*ACC_W +: ACC_W]);
    endfunction

    function automatic int lo_of(input int s);
        return int'(lo_v[s*8 +: 8]);
    endfunction

    function automatic int hi_of(input int s);
        return int'(hi_v[s*8 +: 8]);
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Model of one accepted sample, written from the requirements.
    task automatic model(input bit md, input int idx, input int code);
        int sec;
        int dv;
        sec = -1;
        for (int s = NS - 1; s >= 0; s--)
            if (idx >= lo_of(s) && idx <= hi_of(s)) sec = s;
        if (!md) begin
            if (m_first) begin
                m_min[idx] = code;
                m_max[idx] = code;
            end else begin
                if (code < m_min[idx]) m_min[idx] = code;
                if (code > m_max[idx]) m_max[idx] = code;
            end
            if (idx == hi_of(NS - 1)) m_first = 1'b0;
        end else begin
            if (sec >= 0) begin
                if (e_restart) begin
                    for (int s = 0; s < NS; s++) begin
                        e_num[s] = 0;
                        e_den[s] = 0;
                    end
                    e_restart = 1'b0;
                end
                if (code > m_max[idx])      dv = code - m_max[idx];
                else if (code < m_min[idx]) dv = m_min[idx] - code;
                else                        dv = 0;
                e_num[sec] += dv;
                e_den[sec] += m_max[idx] - m_min[idx];
            end
            if (idx == hi_of(NS - 1)) begin
                for (int s = 0; s < NS; s++) begin
                    q_num.push_back(e_num[s]);
                    q_den.push_back(e_den[s]);
                    q_fail.push_back(((longint'(e_num[s]) * 100 > longint'(thr) * e_den[s]) ||
                                      (e_den[s] == 0 && e_num[s] != 0)) ? 1 : 0);
                end
                e_restart = 1'b1;
            end
        end
    endtask

    task automatic send(input bit md, input int idx, input int code);
        @(negedge clk);
        vld   = 1'b1;
        mode  = md;
        sidx  = IDX_W'(idx);
        scode = 12'(code);
        model(md, idx, code);
        @(posedge clk);
        #1 vld = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        m_first = 1'b1;
        for (int s = 0; s < NS; s++) begin
            e_num[s] = 0;
            e_den[s] = 0;
        end
        e_restart = 1'b1;
        @(posedge clk);
        #1 clr = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic cap4(input bit md, input int c0, input int c1, input int c2, input int c3);
        send(md, 0, c0);
        send(md, 1, c1);
        send(md, 2, c2);
        send(md, 3, c3);
    endtask

    function automatic int base_wave(input int i);
        if (i < 8)  return 300;
        if (i < 24) return 300 + (i - 8) * 200;
        if (i < 40) return 3500;
        if (i < 56) return 3500 - (i - 40) * 200;
        return 300;
    endfunction

    function automatic int golden(input int g, input int i);
        return base_wave(i) + ((i * 7 + g * 5) % 9) - 4;
    endfunction

    // Scoreboard monitor: compares each completion against the queue.
    always @(negedge clk) begin
        if (rst_n && done_w) begin
            if (q_num.size() < NS) begin
                chk("R8 unexpected done pulse", 1, 0);
            end else begin
                int any;
                any = 0;
                for (int s = 0; s < NS; s++) begin
                    int en;
                    int ed;
                    int ef;
                    en = q_num.pop_front();
                    ed = q_den.pop_front();
                    ef = q_fail.pop_front();
                    any |= ef;
                    chk($sformatf("R7 num sec%0d", s), gnum(s), en);
                    chk($sformatf("R7 den sec%0d", s), gden(s), ed);
                    chk($sformatf("R9 fail sec%0d", s), sfail[s], ef);
                end
                chk("R9 fail_o", fail_w, any);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL R8 watchdog: actual %0d cycles expected fewer", cyc);
            summary();
        end
    end

    initial begin
        // Single-index sections 0..3, threshold 5 percent.
        lo_v = {8'd3, 8'd2, 8'd1, 8'd0};
        hi_v = {8'd3, 8'd2, 8'd1, 8'd0};
        thr  = 7'd5;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 num", longint'(num_w != '0), 0);
        chk("R13 den", longint'(den_w != '0), 0);
        chk("R13 done", done_w, 0);
        chk("R13 fail", fail_w, 0);

        do_clear();
        cap4(1'b0, 1000, 1000, 1000, 1000);
        cap4(1'b0, 1100, 1100, 1100, 1100);
        cap4(1'b0, 1050, 1050, 950, 1050);
        cap4(1'b1, 1105, 1106, 950, 994);
        settle();
        chk("R3 above max", gnum(0), 5);
        chk("R4 below min", gnum(3), 6);
        chk("R5 on lower bound", gnum(2), 0);
        chk("R2 widened band", gden(2), 150);
        chk("R9 equality passes", sfail, 4'b1010);

        // R11 restart after completion
        cap4(1'b1, 1106, 1100, 1100, 1100);
        settle();
        chk("R11 restart sec0", gnum(0), 6);
        chk("R11 restart sec3", gnum(3), 0);

        // R12 clear with a closing sample in the same cycle
        @(negedge clk);
        clr = 1'b1; vld = 1'b1; mode = 1'b1; sidx = 8'd3; scode = 12'd4095;
        m_first = 1'b1;
        for (int s = 0; s < NS; s++) begin
            e_num[s] = 0;
            e_den[s] = 0;
        end
        e_restart = 1'b1;
        @(posedge clk);
        #1 begin clr = 1'b0; vld = 1'b0; end
        @(negedge clk);
        chk("R12 no done", done_w, 0);
        chk("R12 num zeroed", gnum(0), 0);
        chk("R12 num3 zeroed", gnum(3), 0);

        // R1 first capture loads directly; R10 zero denominator
        cap4(1'b0, 500, 500, 500, 500);
        cap4(1'b1, 500, 501, 499, 500);
        settle();
        chk("R1 zero band", gden(1), 0);
        chk("R1 dev above", gnum(1), 1);
        chk("R10 zero den verdicts", sfail, 4'b0110);

        // Four 16-index sections, threshold 10 percent.
        lo_v = {8'd48, 8'd32, 8'd16, 8'd0};
        hi_v = {8'd63, 8'd47, 8'd31, 8'd15};
        thr  = 7'd10;
        do_clear();
        for (int g = 0; g < 3; g++) begin
            for (int i = 0; i < 63; i++) send(1'b0, i, golden(g, i));
            send(1'b0, 100, 2000);
            send(1'b0, 63, golden(g, 63));
        end
        // Device within the band, plus an out-of-section extreme
        for (int i = 0; i < 63; i++) send(1'b1, i, golden(1, i));
        send(1'b1, 100, 4095);
        send(1'b1, 63, golden(1, 63));
        settle();
        for (int s = 0; s < NS; s++) chk("R6 outside ignored", gnum(s), 0);

        // Device with section 2 raised
        for (int i = 0; i < 64; i++)
            send(1'b1, i, golden(0, i) + ((i >= 32 && i < 48) ? 40 : 0));
        settle();

        // Overlapping sections: 10..15 belong to section 0 by priority (R6)
        lo_v = {8'd48, 8'd32, 8'd10, 8'd0};
        for (int i = 0; i < 64; i++)
            send(1'b1, i, (i == 5) ? 0 : base_wave(i) + ((i * 3) % 13) - 6);
        settle();

        chk("R8 pending completions", q_num.size(), 0);
        summary();
    end
endmodule